// File: doc/BRIEF.md
# Bus Timing and Timeout Monitor

This block observes the already-synchronised clock and data lines of a two-wire power-management bus and measures how long each line holds a level. The counts advance on a tick produced by a programmable divider running off the system clock. Three conditions are timed: the bus being free (both lines high), the clock line being stuck low, and the clock line staying high while a message is in progress. One selector input chooses whether the thresholds are the values built into the block's parameters or values supplied on the threshold inputs.

Each timed condition sets a sticky flag that clears when the status-read strobe is pulsed. A single interrupt output is raised when any pending source is enabled by its mask bit. For the stuck-low source, a polarity input decides whether the interrupt is taken when the timeout starts or when it ends. The block also keeps a registered copy of the two line levels for status.

Every duration is timed by the same state machine with three states. OFF means the condition is false and the count is cleared. RUN means the condition is true and ticks are being counted. HIT means the threshold has been reached and counting has stopped. The transitions are: OFF to RUN when the condition becomes true; RUN to HIT on the tick that brings the count to the threshold; RUN to OFF and HIT to OFF as soon as the condition drops.

Top module: `pmb_line_watch`

## Requirements
- R1: The count tick occurs once every `clk_div`+1 system clocks. A condition is flagged no earlier than (T-1)·(`clk_div`+1)+1 clocks and no later than T·(`clk_div`+1) clocks after the first clock edge at which it is true, where T is the threshold.
- R2: `bus_free_flag` sets once `scl_in` and `sda_in` have both been high for the idle threshold in ticks.
- R3: `low_to_flag` sets once `scl_in` has been low for the low threshold in ticks. While `low_to_dis` is 1, the stuck-low condition is never detected.
- R4: `high_flag` sets once `scl_in` has been high for the high threshold in ticks while `msg_active` is 1. With `msg_active` at 0, `high_flag` never sets.
- R5: With `tim_ovr`=0 the built-in thresholds (parameters DEF_IDLE, DEF_LOW, DEF_HIGH) apply and the threshold inputs have no effect. With `tim_ovr`=1 the values on `thr_idle`, `thr_low` and `thr_high` apply.
- R6: A duration restarts from zero whenever the monitored condition goes false, even for a short glitch.
- R7: Each duration fires at most once per episode. After the flag is cleared, it does not set again until the condition has gone false and then been held true for the full threshold.
- R8: `scl_raw` and `sda_raw` read 1 during reset. Outside reset they show `scl_in` and `sda_in` one clock later.
- R9: Flags are sticky: they stay set after the condition ends. A one-clock `sts_rd` pulse clears them at the next clock edge. If a flag's set event arrives in the same cycle as the read, the set wins.
- R10: `irq` is 1 whenever a pending source has its `irq_mask` bit at 0. A mask bit of 1 disables its source. Bit 0 is bus-free, bit 1 is stuck-low and bit 2 is clock-high.
- R11: With `low_irq_fall`=0 the stuck-low interrupt pends when the timeout begins. With `low_irq_fall`=1 it pends when the timeout ends, which happens when `scl_in` rises or detection is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised bus clock line level |
| sda_in | input | 1 | Synchronised bus data line level |
| msg_active | input | 1 | A message is in progress |
| clk_div | input | DIV_W (5) | Tick divider; tick period is value+1 clocks |
| tim_ovr | input | 1 | 1 selects the threshold inputs, 0 the built-in thresholds |
| thr_idle | input | IDLE_W (10) | Programmed bus-free threshold in ticks |
| thr_low | input | LOW_W (20) | Programmed stuck-low threshold in ticks |
| thr_high | input | HIGH_W (10) | Programmed clock-high threshold in ticks |
| low_to_dis | input | 1 | Disables stuck-low detection |
| low_irq_fall | input | 1 | Stuck-low interrupt on the end (1) or start (0) of the timeout |
| irq_mask | input | 3 | Per-source disable, 1 = disabled |
| sts_rd | input | 1 | Status read strobe; clears the flags |
| scl_raw | output | 1 | Registered clock line level |
| sda_raw | output | 1 | Registered data line level |
| bus_free_flag | output | 1 | Sticky bus-free flag |
| low_to_flag | output | 1 | Sticky stuck-low timeout flag |
| high_flag | output | 1 | Sticky clock-high-in-message flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with small built-in thresholds: 12 ticks for bus-free, 30 for stuck-low and 9 for clock-high. This lets the default-threshold path, which the 0x1F3 / 0x5572F production values would put out of reach, be exercised cycle-exactly within a short run. Driving the threshold inputs with different values while the override is off shows they are ignored. Random thresholds between 4 and 20 ticks and divider values 0 to 3 then test the override path together with the tick spacing at both edges of the timing window.

// File: rtl/pmb_watch_pkg.sv
package pmb_watch_pkg;

    typedef enum logic [1:0] {
        SPAN_OFF = 2'd0,
        SPAN_RUN = 2'd1,
        SPAN_HIT = 2'd2
    } span_state_e;

    localparam int NSRC     = 3;
    localparam int SRC_IDLE = 0;
    localparam int SRC_LOW  = 1;
    localparam int SRC_HIGH = 2;

endpackage

// File: rtl/pmb_tick_div.sv
module pmb_tick_div #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick); // R1

endmodule

// File: rtl/pmb_span_cnt.sv
module pmb_span_cnt
    import pmb_watch_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cond,
    input  logic [W-1:0] limit,
    output logic         hit,
    output logic         fire
);

    span_state_e  st_q, st_nx;
    logic [W-1:0] cnt_q, cnt_nx;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SPAN_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // next state and outputs
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        fire   = 1'b0;
        unique case (st_q)
            SPAN_OFF: begin
                cnt_nx = '0;
                if (cond) st_nx = SPAN_RUN;
            end
            SPAN_RUN: begin
                if (!cond) begin
                    st_nx  = SPAN_OFF;
                    cnt_nx = '0;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, limit}) begin
                        st_nx = SPAN_HIT;
                        fire  = 1'b1;
                    end else begin
                        cnt_nx = cnt_inc[W-1:0];
                    end
                end
            end
            SPAN_HIT: begin
                if (!cond) begin
                    st_nx  = SPAN_OFF;
                    cnt_nx = '0;
                end
            end
            default: st_nx = SPAN_OFF;
        endcase
    end

    assign hit = (st_q == SPAN_HIT);

    AST_SPAN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> !hit); // R6
    AST_SPAN_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !fire); // R7
    AST_SPAN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(fire)); // R7

endmodule

// File: rtl/pmb_line_watch.sv
module pmb_line_watch
    import pmb_watch_pkg::*;
#(
    parameter int DIV_W    = 5,
    parameter int IDLE_W   = 10,
    parameter int LOW_W    = 20,
    parameter int HIGH_W   = 10,
    parameter int DEF_IDLE = 'h1F3,
    parameter int DEF_LOW  = 'h5572F,
    parameter int DEF_HIGH = 'h1F3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              msg_active,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              tim_ovr,
    input  logic [IDLE_W-1:0] thr_idle,
    input  logic [LOW_W-1:0]  thr_low,
    input  logic [HIGH_W-1:0] thr_high,
    input  logic              low_to_dis,
    input  logic              low_irq_fall,
    input  logic [NSRC-1:0]   irq_mask,
    input  logic              sts_rd,
    output logic              scl_raw,
    output logic              sda_raw,
    output logic              bus_free_flag,
    output logic              low_to_flag,
    output logic              high_flag,
    output logic              irq
);

    localparam logic [IDLE_W-1:0] DEF_IDLE_V = IDLE_W'(DEF_IDLE);
    localparam logic [LOW_W-1:0]  DEF_LOW_V  = LOW_W'(DEF_LOW);
    localparam logic [HIGH_W-1:0] DEF_HIGH_V = HIGH_W'(DEF_HIGH);

    logic              tick;
    logic [IDLE_W-1:0] lim_idle;
    logic [LOW_W-1:0]  lim_low;
    logic [HIGH_W-1:0] lim_high;
    logic              cond_idle, cond_low, cond_high;
    logic              hit_idle, hit_low, hit_high;
    logic              fire_idle, fire_low, fire_high;
    logic              low_hit_q, low_fall;
    logic [NSRC-1:0]   flag_set, pend_set, flag_q, pend_q;

    pmb_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div(clk_div), .tick(tick)
    );

    assign lim_idle  = tim_ovr ? thr_idle : DEF_IDLE_V;
    assign lim_low   = tim_ovr ? thr_low  : DEF_LOW_V;
    assign lim_high  = tim_ovr ? thr_high : DEF_HIGH_V;

    assign cond_idle = scl_in & sda_in;
    assign cond_low  = ~scl_in & ~low_to_dis;
    assign cond_high = scl_in & msg_active;

    pmb_span_cnt #(.W(IDLE_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cond(cond_idle),
        .limit(lim_idle), .hit(hit_idle), .fire(fire_idle)
    );
    pmb_span_cnt #(.W(LOW_W)) u_low (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cond(cond_low),
        .limit(lim_low), .hit(hit_low), .fire(fire_low)
    );
    pmb_span_cnt #(.W(HIGH_W)) u_high (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cond(cond_high),
        .limit(lim_high), .hit(hit_high), .fire(fire_high)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_raw   <= 1'b1;
            sda_raw   <= 1'b1;
            low_hit_q <= 1'b0;
        end else begin
            scl_raw   <= scl_in;
            sda_raw   <= sda_in;
            low_hit_q <= hit_low;
        end
    end

    assign low_fall = low_hit_q & ~hit_low;

    assign flag_set[SRC_IDLE] = fire_idle;
    assign flag_set[SRC_LOW]  = fire_low;
    assign flag_set[SRC_HIGH] = fire_high;
    assign pend_set[SRC_IDLE] = fire_idle;
    assign pend_set[SRC_LOW]  = low_irq_fall ? low_fall : fire_low;
    assign pend_set[SRC_HIGH] = fire_high;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                flag_q[g] <= (flag_q[g] & ~sts_rd) | flag_set[g];
                pend_q[g] <= (pend_q[g] & ~sts_rd) | pend_set[g];
            end
        end

        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_rd && !flag_set[g]) |=> !flag_q[g]); // R9
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !sts_rd) |=> flag_q[g]); // R9
    end

    assign bus_free_flag = flag_q[SRC_IDLE];
    assign low_to_flag   = flag_q[SRC_LOW];
    assign high_flag     = flag_q[SRC_HIGH];
    assign irq           = |(pend_q & ~irq_mask);

    AST_RAW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> scl_raw == $past(scl_in)); // R8
    AST_LOW_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        low_to_dis |-> !fire_low); // R3
    AST_HIGH_NEEDS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        fire_high |-> msg_active); // R4
    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&irq_mask) |-> !irq); // R10

endmodule

// File: tb/test_pmb_line_watch.sv
module test_pmb_line_watch;
    localparam int DI = 12;
    localparam int DL = 30;
    localparam int DH = 9;

    logic        clk = 1'b0;
    logic        rst_n, scl_in, sda_in, msg_active, tim_ovr, low_to_dis, low_irq_fall, sts_rd;
    logic [4:0]  clk_div;
    logic [9:0]  thr_idle, thr_high;
    logic [19:0] thr_low;
    logic [2:0]  irq_mask;
    logic        scl_raw, sda_raw, bus_free_flag, low_to_flag, high_flag, irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;

    always #2 clk = ~clk;

    pmb_line_watch #(.DEF_IDLE(DI), .DEF_LOW(DL), .DEF_HIGH(DH)) i_pmb_line_watch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .msg_active(msg_active), .clk_div(clk_div), .tim_ovr(tim_ovr),
        .thr_idle(thr_idle), .thr_low(thr_low), .thr_high(thr_high),
        .low_to_dis(low_to_dis), .low_irq_fall(low_irq_fall), .irq_mask(irq_mask),
        .sts_rd(sts_rd), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .bus_free_flag(bus_free_flag), .low_to_flag(low_to_flag),
        .high_flag(high_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int flag_of(input int kind);
        case (kind)
            0:       return int'(bus_free_flag);
            1:       return int'(low_to_flag);
            default: return int'(high_flag);
        endcase
    endfunction

    // last edge count at which the flag must still be clear, and one by which it must be set
    function automatic int quiet_edges(input int t, input int d);
        return (t - 1) * (d + 1);
    endfunction
    function automatic int sure_edges(input int t, input int d);
        return t * (d + 1) + 1;
    endfunction

    task automatic prep(input int kind);
        @(negedge clk);
        sts_rd = 1'b1;
        case (kind)
            0:       begin scl_in = 0; sda_in = 0; msg_active = 0; end
            1:       begin scl_in = 1; sda_in = 1; msg_active = 0; end
            default: begin scl_in = 0; sda_in = 0; msg_active = 1; end
        endcase
        @(negedge clk);
        sts_rd = 1'b0;
        case (kind)
            0:       begin scl_in = 1; sda_in = 1; end
            1:       scl_in = 0;
            default: scl_in = 1;
        endcase
    endtask

    task automatic win(input int kind, input int t, input int d, input string req);
        prep(kind);
        repeat (quiet_edges(t, d)) @(posedge clk);
        #1 chk(req, flag_of(kind), 0);
        repeat (sure_edges(t, d) - quiet_edges(t, d)) @(posedge clk);
        #1 chk(req, flag_of(kind), 1);
    endtask

    task automatic rd_pulse();
        @(negedge clk); sts_rd = 1'b1;
        @(negedge clk); sts_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; scl_in = 0; sda_in = 0; msg_active = 0; tim_ovr = 0;
        low_to_dis = 0; low_irq_fall = 0; sts_rd = 0; clk_div = 0;
        thr_idle = 10'd3; thr_low = 20'd3; thr_high = 10'd3; irq_mask = 3'b111;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 scl_raw in reset", int'(scl_raw), 1);
        chk("R8 sda_raw in reset", int'(sda_raw), 1);
        chk("R9 flags in reset", int'({bus_free_flag, low_to_flag, high_flag}), 0);
        chk("R10 irq in reset", int'(irq), 0);
        @(negedge clk); rst_n = 1; scl_in = 0; sda_in = 1;
        @(posedge clk); #1;
        chk("R8 scl_raw follows", int'(scl_raw), 0);
        chk("R8 sda_raw follows", int'(sda_raw), 1);

        // built-in thresholds, programmed inputs set to 3 must be ignored
        win(0, DI, 0, "R2 R5 default idle");
        // mask checks with only the bus-free source pending
        irq_mask = 3'b111; #1 chk("R10 all masked", int'(irq), 0);
        irq_mask = 3'b110; #1 chk("R10 idle enabled", int'(irq), 1);
        irq_mask = 3'b101; #1 chk("R10 other source enabled", int'(irq), 0);
        irq_mask = 3'b111;
        // sticky after condition ends
        @(negedge clk); scl_in = 0;
        repeat (5) @(posedge clk);
        #1 chk("R9 sticky", int'(bus_free_flag), 1);
        win(1, DL, 0, "R3 R5 default low");
        win(2, DH, 0, "R4 R5 default high");

        // once per episode and clear on read: still in high-time HIT
        @(negedge clk); sts_rd = 1;
        @(posedge clk); #1 chk("R9 read clears", int'(high_flag), 0);
        @(negedge clk); sts_rd = 0;
        repeat (3 * DH) @(posedge clk);
        #1 chk("R7 no refire", int'(high_flag), 0);

        // high time without a message
        @(negedge clk); sts_rd = 1; scl_in = 0; msg_active = 0;
        @(negedge clk); sts_rd = 0; scl_in = 1; sda_in = 0;
        repeat (3 * DH) @(posedge clk);
        #1 chk("R4 no message", int'(high_flag), 0);

        // low timeout disabled
        low_to_dis = 1;
        prep(1);
        repeat (3 * DL) @(posedge clk);
        #1 chk("R3 disabled", int'(low_to_flag), 0);
        low_to_dis = 0;

        // restart after a glitch
        prep(1);
        repeat (DL - 1) @(posedge clk);
        #1 chk("R6 before glitch", int'(low_to_flag), 0);
        @(negedge clk); scl_in = 1;
        repeat (2) @(posedge clk);
        @(negedge clk); scl_in = 0;
        repeat (DL - 1) @(posedge clk);
        #1 chk("R6 restarted", int'(low_to_flag), 0);
        repeat (2) @(posedge clk);
        #1 chk("R6 fires after full span", int'(low_to_flag), 1);

        // interrupt edge select on the stuck-low source
        irq_mask = 3'b101;
        win(1, DL, 0, "R3 rising edge setup");
        chk("R11 rising edge irq", int'(irq), 1);
        @(negedge clk); scl_in = 1;
        repeat (3) @(posedge clk);
        rd_pulse();
        low_irq_fall = 1;
        win(1, DL, 0, "R3 falling edge setup");
        chk("R11 no irq at entry", int'(irq), 0);
        @(negedge clk); scl_in = 1;
        repeat (2) @(posedge clk);
        #1 chk("R11 irq at exit", int'(irq), 1);
        irq_mask = 3'b111; low_irq_fall = 0;
        repeat (3) @(posedge clk);
        rd_pulse();

        // programmed thresholds with a divider
        tim_ovr = 1; clk_div = 5'd3;
        thr_idle = 10'd7; thr_low = 20'd9; thr_high = 10'd5;
        win(0, 7, 3, "R1 R5 override idle");
        win(1, 9, 3, "R1 R5 override low");
        win(2, 5, 3, "R1 R5 override high");

        for (int it = 0; it < 12; it++) begin
            int kind = int'($urandom % 3);
            int t    = 4 + int'($urandom % 17);
            int d    = int'($urandom % 4);
            @(negedge clk);
            clk_div = 5'(d);
            thr_idle = 10'(t); thr_low = 20'(t); thr_high = 10'(t);
            win(kind, t, d, "R1 R2 R3 R4 random");
        end
        finish_run();
    end
endmodule